// File: doc/BRIEF.md
# Hierarchical Interrupt Status Aggregator

This block gathers interrupt events from twelve line channels and presents them to a host as a two-level status tree on a byte-wide synchronous register bus. Every channel owns a sticky source-status register, where each event input sets its own bit, and a host-written enable register that decides which of those bits may raise an interrupt. The summary view packs six channels into each of two byte registers, so a service routine reads a summary byte first, picks a channel from it, and then reads that channel's source-status register.

A summary bit is sticky. Once a channel has an enabled pending source, its bit stays set until the host reads that channel's source-status register. That read also clears every latched source of the channel. Reading the summary register leaves it unchanged. An active-low interrupt line is low whenever any summary bit is set.

Top module: `irq_agg`

## Requirements
- R1: After reset, every source latch, every enable register and every summary bit is 0, `irq_n` is 1 and `bus_rdata` is 0.
- R2: A 1 on bit b of channel c's event inputs in any cycle sets source bit b of that channel on the next edge, and the bit stays set with no further event. Channel c (0 to 5) has its source-status register at 0x02 + 0x10*c. Channel 6+k has it at 0x82 + 0x10*k.
- R3: A read of a channel's source-status register returns the latched bits held before the read, and clears all of them on the same edge. An event that arrives in the read cycle stays latched. That channel's summary bit reads 0 in the cycle after the read.
- R4: Each channel's enable register sits one address above its source-status register. It can be read and written, resets to 0, and bit b gates source b.
- R5: Summary register 0x61 reports channels 0 to 5 in bits 0 to 5. Summary register 0xE1 reports channels 6 to 11 in bits 0 to 5. Bits 7 and 6 of both read 0.
- R6: A summary bit rises one edge after its channel holds a latched source whose enable bit is 1. A latched source whose enable bit is 0 never sets it.
- R7: Once set, a summary bit stays 1 when the summary register is read and when the channel's enable bits are cleared. Only a read of that channel's source-status register clears it.
- R8: `irq_n` is 0 exactly when at least one summary bit is 1.
- R9: A read of an unmapped address returns 0. Writes to source-status, summary or unmapped addresses change no state.
- R10: Read data appears on `bus_rdata` on the edge that follows the read strobe, and it holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| line_evt | input | NUM_CH*SRC_W (96) | Event inputs, channel c on bits [c*SRC_W +: SRC_W] |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
The bench targets a summary bit that is set while its source has already been masked. A design that derives the summary combinationally from the sources would drop that bit. It also targets an event that lands in the same cycle as the source read: a design that lets the clear win would lose that event, and would leave the summary bit low afterwards. Further cases cover summary reads that must leave the summary unchanged, the upper channel group at its shifted addresses, and writes aimed at read-only addresses. A design that failed these would drift from the model within a cycle. A long random phase mixes events, enable writes and reads, and compares both outputs against a behavioural model on every clock.

// File: rtl/irq_agg_pkg.sv
// Package irq_agg_pkg
// Holds the types and the address decode shared by the aggregator's modules.
// It assumes a byte address split as {group, slot[2:0], offset[3:0]}, with six
// channel slots per group and the group summary in slot 6.
package irq_agg_pkg;

    localparam int GRP_CH  = 6;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;

    localparam logic [3:0] OFS_SRC = 4'h2;
    localparam logic [3:0] OFS_EN  = 4'h3;
    localparam logic [3:0] OFS_SUM = 4'h1;
    localparam logic [2:0] SLOT_SUM = 3'd6;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SRC  = 2'd1,
        ACC_EN   = 2'd2,
        ACC_SUM  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic [3:0] ch;
        logic       grp;
    } acc_dec_t;

    // Turns a bus address into an access kind and, where it applies, a channel.
    function automatic acc_dec_t decode_addr(input logic [ADDR_W-1:0] a, input int n_ch);
        acc_dec_t d;
        int       ch;
        d.kind = ACC_NONE;
        d.ch   = '0;
        d.grp  = a[7];
        ch     = int'(a[7]) * GRP_CH + int'(a[6:4]);
        if (a[6:4] == SLOT_SUM && a[3:0] == OFS_SUM) begin
            d.kind = ACC_SUM;
        end else if (int'(a[6:4]) < GRP_CH && ch < n_ch) begin
            d.ch = ch[3:0];
            if (a[3:0] == OFS_SRC) begin
                d.kind = ACC_SRC;
            end else if (a[3:0] == OFS_EN) begin
                d.kind = ACC_EN;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/irq_src_bank.sv
// Module irq_src_bank
// One channel's sticky source latches and its enable register.
// It assumes the clear strobe is one cycle long. An event in the clear cycle wins
// over the clear, so no event is lost.
module irq_src_bank #(
    parameter int SRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] evt,
    input  logic             rd_clr,
    input  logic             en_we,
    input  logic [SRC_W-1:0] en_wdata,
    output logic [SRC_W-1:0] latch_q,
    output logic [SRC_W-1:0] en_q,
    output logic             pend
);

    // Sticky latches: cleared by a source read, set by any event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= (rd_clr ? '0 : latch_q) | evt;
        end
    end

    // Enable register, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_we) begin
            en_q <= en_wdata;
        end
    end

    // Channel has an enabled source awaiting service.
    always_comb begin
        pend = |(latch_q & en_q);
    end

endmodule

// File: rtl/irq_summary.sv
// Module irq_summary
// Sticky channel-level summary bits.
// It assumes pend comes from registered latches and that clr is a one-cycle
// source-read strobe for each channel.
module irq_summary #(
    parameter int NUM_CH = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pend,
    input  logic [NUM_CH-1:0] clr,
    output logic [NUM_CH-1:0] sum_q
);

    // A source read clears the bit; otherwise a pending channel sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= ~clr & (sum_q | pend);
        end
    end

endmodule

// File: rtl/irq_bus_if.sv
// Module irq_bus_if
// Register-bus front end. It decodes addresses, raises the write-enable and
// clear-on-read strobes, and registers the read data one clock after the strobe.
// It assumes single-cycle strobes. A read and a write in one cycle are both
// served, and the read returns the value held before the write.
module irq_bus_if
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int SRC_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [NUM_CH*SRC_W-1:0]  lat_flat,
    input  logic [NUM_CH*SRC_W-1:0]  en_flat,
    input  logic [NUM_CH-1:0]        sum_q,
    output logic [NUM_CH-1:0]        src_clr,
    output logic [NUM_CH-1:0]        en_we,
    output logic [DATA_W-1:0]        bus_rdata
);

    acc_dec_t          dec;
    logic [DATA_W-1:0] rd_mux;

    // Decode the current address.
    always_comb begin
        dec = decode_addr(bus_addr, NUM_CH);
    end

    // Per-channel strobes: clear on a source read, load on an enable write.
    always_comb begin
        src_clr = '0;
        en_we   = '0;
        if (bus_rd && dec.kind == ACC_SRC) begin
            src_clr[dec.ch] = 1'b1;
        end
        if (bus_wr && dec.kind == ACC_EN) begin
            en_we[dec.ch] = 1'b1;
        end
    end

    // Read multiplexer; reserved and unmapped bits stay 0.
    always_comb begin
        rd_mux = '0;
        case (dec.kind)
            ACC_SRC: rd_mux[SRC_W-1:0] = lat_flat[int'(dec.ch)*SRC_W +: SRC_W];
            ACC_EN:  rd_mux[SRC_W-1:0] = en_flat[int'(dec.ch)*SRC_W +: SRC_W];
            ACC_SUM: begin
                for (int i = 0; i < GRP_CH; i++) begin
                    if (int'(dec.grp) * GRP_CH + i < NUM_CH) begin
                        rd_mux[i] = sum_q[int'(dec.grp) * GRP_CH + i];
                    end
                end
            end
            default: rd_mux = '0;
        endcase
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/irq_agg.sv
// Module irq_agg
// Top level of the two-level interrupt status aggregator. It instantiates one
// source bank per channel, the sticky summary and the bus front end, and it
// drives the active-low combined interrupt.
// It assumes NUM_CH <= 12 (two groups of six) and SRC_W <= 8.
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int SRC_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_rd,
    input  logic                    bus_wr,
    input  logic [7:0]              bus_addr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    input  logic [NUM_CH*SRC_W-1:0] line_evt,
    output logic                    irq_n
);

    logic [NUM_CH*SRC_W-1:0] lat_flat;
    logic [NUM_CH*SRC_W-1:0] en_flat;
    logic [NUM_CH-1:0]       pend;
    logic [NUM_CH-1:0]       src_clr;
    logic [NUM_CH-1:0]       en_we;
    logic [NUM_CH-1:0]       sum_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        irq_src_bank #(.SRC_W(SRC_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (line_evt[c*SRC_W +: SRC_W]),
            .rd_clr   (src_clr[c]),
            .en_we    (en_we[c]),
            .en_wdata (bus_wdata[SRC_W-1:0]),
            .latch_q  (lat_flat[c*SRC_W +: SRC_W]),
            .en_q     (en_flat[c*SRC_W +: SRC_W]),
            .pend     (pend[c])
        );
    end

    irq_summary #(.NUM_CH(NUM_CH)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .clr   (src_clr),
        .sum_q (sum_q)
    );

    irq_bus_if #(.NUM_CH(NUM_CH), .SRC_W(SRC_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .lat_flat  (lat_flat),
        .en_flat   (en_flat),
        .sum_q     (sum_q),
        .src_clr   (src_clr),
        .en_we     (en_we),
        .bus_rdata (bus_rdata)
    );

    // Combined interrupt: low while any summary bit is set.
    always_comb begin
        irq_n = ~|sum_q;
    end

endmodule

// File: rtl/irq_agg_chk.sv
// Module irq_agg_chk
// Assertion checker attached to irq_agg through a bind statement. It watches the
// bus outputs and the strobes and summary state that different submodules drive.
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [7:0]        bus_addr,
    input logic [7:0]        bus_rdata,
    input logic [NUM_CH-1:0] sum_q,
    input logic [NUM_CH-1:0] pend,
    input logic [NUM_CH-1:0] src_clr
);

    logic dec_none;
    logic dec_sum;

    // Address class of the current access, for the read-data checks.
    always_comb begin
        dec_none = (decode_addr(bus_addr, NUM_CH).kind == ACC_NONE);
        dec_sum  = (decode_addr(bus_addr, NUM_CH).kind == ACC_SUM);
    end

    // R10: read data changes only after a read strobe.
    a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));

    // R5: reserved summary bits read zero.
    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && dec_sum) |-> (bus_rdata[7:6] == 2'b00));

    // R9: unmapped reads return zero.
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && dec_none) |-> (bus_rdata == 8'h00));

    // R7: a summary bit falls only after its channel's source read.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sum_q) & ~$past(src_clr) & ~sum_q) == '0));

    // R6: a summary bit rises only after its channel had an enabled pending source.
    a_r6_rise_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        ((sum_q & ~$past(sum_q) & ~$past(pend)) == '0));

    // R3: the cycle after a source read, that channel's summary bit is 0.
    a_r3_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(src_clr) & sum_q) == '0));

endmodule

bind irq_agg irq_agg_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .sum_q     (sum_q),
    .pend      (pend),
    .src_clr   (src_clr)
);

// File: tb/irq_agg_test.sv
// Bench for irq_agg. A behavioural model kept in integer arrays is stepped on
// every rising edge and compared with the outputs on every falling edge.
// Directed checks add named checks on top of that comparison.
module irq_agg_test;

    localparam int NCH = 12;
    localparam int SW  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_rd = 1'b0;
    logic            bus_wr = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [7:0]      bus_wdata = '0;
    logic [7:0]      bus_rdata;
    logic [NCH*SW-1:0] line_evt = '0;
    logic            irq_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    // Model state.
    int    m_lat [NCH];
    int    m_en  [NCH];
    bit    m_sum [NCH];
    int    exp_rd = 0;
    bit    exp_irq_n = 1'b1;
    string exp_tag = "R1";

    irq_agg #(.NUM_CH(NCH), .SRC_W(SW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .line_evt  (line_evt),
        .irq_n     (irq_n)
    );

    always #2 clk = ~clk;

    function automatic int src_addr(int c);
        return (c / 6) * 128 + (c % 6) * 16 + 2;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model, one step per rising edge.
    always @(posedge clk) begin
        int  cs, ce, gs, v;
        bit  any;
        cycles++;
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_lat[c] = 0; m_en[c] = 0; m_sum[c] = 1'b0;
            end
            exp_rd = 0;
            exp_tag = "R1";
        end else begin
            cs = -1; ce = -1; gs = -1;
            for (int c = 0; c < NCH; c++) begin
                if (int'(bus_addr) == src_addr(c)) cs = c;
                if (int'(bus_addr) == src_addr(c) + 1) ce = c;
            end
            if (bus_addr == 8'h61) gs = 0;
            if (bus_addr == 8'hE1) gs = 1;
            if (bus_rd) begin
                if (cs >= 0) begin
                    exp_rd = m_lat[cs]; exp_tag = "R3";
                end else if (ce >= 0) begin
                    exp_rd = m_en[ce]; exp_tag = "R4";
                end else if (gs >= 0) begin
                    v = 0;
                    for (int i = 0; i < 6; i++) if (m_sum[gs*6+i]) v = v | (1 << i);
                    exp_rd = v; exp_tag = "R5";
                end else begin
                    exp_rd = 0; exp_tag = "R9";
                end
            end
            for (int c = 0; c < NCH; c++) begin
                bit clr;
                clr = bus_rd && (c == cs);
                if (clr) m_sum[c] = 1'b0;
                else if ((m_lat[c] & m_en[c]) != 0) m_sum[c] = 1'b1;
                m_lat[c] = (clr ? 0 : m_lat[c]) | int'(line_evt[c*SW +: SW]);
            end
            if (bus_wr && ce >= 0) m_en[ce] = int'(bus_wdata);
        end
        any = 1'b0;
        for (int c = 0; c < NCH; c++) any = any | m_sum[c];
        exp_irq_n = !any;
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            check(exp_tag, int'(bus_rdata), exp_rd);
            check("R8", int'(irq_n), int'(exp_irq_n));
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic rd(input logic [7:0] a, output int d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = int'(bus_rdata);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(int c, int b);
        @(negedge clk);
        line_evt[c*SW + b] = 1'b1;
        @(negedge clk);
        line_evt = '0;
    endtask

    initial begin
        int d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        check("R1", int'(irq_n), 1);
        check("R1", int'(bus_rdata), 0);
        rd(8'h61, d); check("R1", d, 0);
        rd(8'h03, d); check("R1", d, 0);

        // Masked source: latched but no summary.
        pulse(0, 3);
        @(negedge clk);
        check("R6", int'(irq_n), 1);
        rd(8'h61, d); check("R6", d, 0);
        rd(8'h02, d); check("R2", d, 8'h08);
        rd(8'h02, d); check("R3", d, 0);

        // Enable register round trip.
        wr(8'h23, 8'hA5);
        rd(8'h23, d); check("R4", d, 8'hA5);

        // Summary latency and the interrupt.
        @(negedge clk);
        line_evt[2*SW + 0] = 1'b1;
        @(negedge clk);
        line_evt = '0;
        check("R6", int'(irq_n), 1);
        @(negedge clk);
        check("R8", int'(irq_n), 0);
        rd(8'h61, d); check("R5", d, 8'h04);
        rd(8'h61, d); check("R7", d, 8'h04);

        // Masking keeps the sticky bit.
        wr(8'h23, 8'h00);
        repeat (2) @(negedge clk);
        rd(8'h61, d); check("R7", d, 8'h04);
        check("R8", int'(irq_n), 0);
        rd(8'h22, d); check("R3", d, 8'h01);
        check("R3", int'(irq_n), 1);
        rd(8'h61, d); check("R3", d, 0);

        // Upper group, channel 9 (0xB2 / 0xB3).
        wr(8'hB3, 8'h80);
        pulse(9, 7);
        @(negedge clk);
        rd(8'hE1, d); check("R5", d, 8'h08);
        // Event in the same cycle as the source read is kept.
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 8'hB2; line_evt[9*SW + 7] = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; line_evt = '0;
        check("R3", int'(bus_rdata), 8'h80);
        @(negedge clk);
        check("R3", int'(irq_n), 0);
        rd(8'hB2, d); check("R3", d, 8'h80);
        @(negedge clk);
        rd(8'hE1, d); check("R3", d, 0);

        // Unmapped reads and ignored writes.
        rd(8'h00, d); check("R9", d, 0);
        rd(8'h62, d); check("R9", d, 0);
        rd(8'h72, d); check("R9", d, 0);
        rd(8'hFF, d); check("R9", d, 0);
        wr(8'h61, 8'hFF);
        wr(8'h02, 8'hFF);
        wr(8'h00, 8'hFF);
        rd(8'h61, d); check("R9", d, 0);
        rd(8'h02, d); check("R9", d, 0);
        rd(8'h03, d); check("R9", d, 0);

        // Read data holds between reads.
        wr(8'h13, 8'h5A);
        rd(8'h13, d);
        repeat (3) @(negedge clk);
        check("R10", int'(bus_rdata), 8'h5A);

        // Random traffic, checked by the per-cycle model comparison.
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++)
                line_evt[c*SW +: SW] = 8'($urandom & $urandom & $urandom & $urandom);
            bus_rd = ($urandom % 2) == 0;
            bus_wr = ($urandom % 5) == 0;
            case ($urandom % 4)
                0: bus_addr = 8'(src_addr(int'($urandom % NCH)));
                1: bus_addr = 8'(src_addr(int'($urandom % NCH)) + 1);
                2: bus_addr = (($urandom % 2) == 0) ? 8'h61 : 8'hE1;
                default: bus_addr = 8'($urandom);
            endcase
            bus_wdata = 8'($urandom);
        end
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; line_evt = '0;
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule